// File: doc/BRIEF.md
# Serial Port Register Bank with Interrupt Combiner

This block is the software-facing front end of a serial port. A host reaches it over a simple 32-bit register bus in which `addr` is a word index (byte offset divided by four). It holds four control registers, a FIFO-control word, baud divisor words, a one-millisecond prescale word, two status registers and a test register. It also holds a receive buffer that takes one character. Bit serialization, baud timing and the line itself stay outside the block. An external receiver hands in finished characters with their flags, and an external transmitter takes one character per strobe and reports back when it is done.

Two small state machines carry the dynamic behaviour. The receive buffer has the states EMPTY and FULL. A character arriving in EMPTY moves it to FULL. A read of the receive-data word in FULL moves it back to EMPTY. A soft reset forces EMPTY. The transmit sequencer has the states IDLE, SEND and WAIT. An accepted write to the transmit-data word moves it from IDLE to SEND, where the strobe is driven for one cycle. From SEND it moves to WAIT, or straight back to IDLE if the done pulse arrives in that same cycle. From WAIT it returns to IDLE on the done pulse. A soft reset forces IDLE. A registered interrupt request combines each status flag with an enable bit placed in one of the control registers.

Bit positions used below: status 1 has TX-ready at bit 13 and RX-ready at bit 9. Status 2 has TX-empty at bit 14, transmit-complete at bit 3, break-seen at bit 2 and data-ready at bit 0. In the test register, RX-empty is bit 5 and TX-empty is bit 6. Control 2 has soft-reset at bit 0 and transmit-enable at bit 2. Control 1 has its TX-empty interrupt enable at bit 6.

Top module: `uart_regbank`

## Requirements
- R1: After power-on reset the register reads are as follows. Status 1 = 0x6040 (bits 14, 13, 6). Status 2 = 0x4028 (bits 14, 5, 3). Test (index 0x2D) = 0x0060. Control 1 (0x20) = 0. Control 2 (0x21) = 0x0001. Control 3 (0x22) = 0x0700. Modulator (0x2A) = 0. Baud count (0x2B) = 4. Receive data (0x00) = 0x4000. In addition, `irq`=0 and `rx_ready`=1.
- R2: Configuration words (indices 0x20-0x24, 0x2A, 0x2C) store only the low 16 bits of a write, and `rdata[31:16]` is always 0. A write to index 0x29 lands in the baud count (0x2B), and a read of 0x29 returns 0. Unmapped indices and the transmit index (0x10) read 0. Writes to unmapped indices and to the test register change nothing.
- R3: A write to control 2 with bit 0 clear is a soft reset. Control 1, control 3, the modulator, the baud count, the receive buffer, break-seen and both state machines return to their R1 values. Control 2 stores the written low 16 bits with bit 0 forced to 1. Control 4, FIFO control and the one-millisecond word keep their contents.
- R4: A character accepted on `rx_valid` is stored as follows: data in bits 7:0, error at bit 14, frame-error at bit 12 and break at bit 11. It sets status-1 bit 9 and status-2 bit 0 and clears test bit 5. A character carrying the break flag also sets status-2 bit 2.
- R5: A read of index 0x00 returns the stored word. While the buffer is FULL, bit 15 is ORed into the result and the buffer returns to EMPTY. While the buffer is EMPTY, the read returns the word without bit 15 and changes nothing.
- R6: `rx_ready` is low exactly while the buffer is FULL. A character that arrives while the buffer is full is discarded and the stored word is kept.
- R7: Writes to status 1 change nothing. Writes to status 2 clear only break-seen (bit 2), and only where a 1 is written.
- R8: A write to index 0x10 while control-2 bit 2 is set starts a transmission. On the next cycle `tx_strobe` is high for exactly one cycle, with `tx_data` equal to the written low byte. Status-1 bit 13 and status-2 bit 3 read 0 until `tx_done`. The write is ignored while transmit-enable is clear or while a character is still in flight.
- R9: `irq` is high when any of the following pairs has both bits set: status-1 bit 13 with control-1 bit 13; status-1 bit 9 with control-1 bit 9; status-2 bit 14 with control-1 bit 6; status-2 bit 3 with control-4 bit 3; status-2 bit 0 with control-4 bit 0.
- R10: `irq` is registered and reflects the state one clock after the edge that changed it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; a read of the receive word pops the buffer |
| addr | input | ADDR_W | Word index of the register |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, combinational, zero when `rd_en` is low |
| rx_valid | input | 1 | Received character offered |
| rx_data | input | CHAR_W | Received character |
| rx_brk | input | 1 | Line break flag with the character |
| rx_frm | input | 1 | Framing error flag with the character |
| rx_err | input | 1 | Error summary flag with the character |
| rx_ready | output | 1 | Buffer can take a character |
| tx_strobe | output | 1 | One-cycle start to the transmitter |
| tx_data | output | CHAR_W | Character to transmit |
| tx_done | input | 1 | Transmitter finished the character |
| irq | output | 1 | Registered level interrupt request |

## Verification
The bench builds the block with its defaults: ADDR_W=6, DATA_W=32, REG_W=16, CHAR_W=8. A 6-bit index reaches the unmapped index 0x3F next to the mapped ones, so decode holes are exercised. A 32-bit bus with 16-bit registers lets the bench write values with the upper half set and see that half dropped. With 8-bit characters, bits 8 to 10 of the receive word stay clear. The break, frame-error and error flags therefore land on distinct, separately checkable bits, and the ready flag ORed in at bit 15 cannot be confused with data.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;

    // Word indices whose values software depends on
    localparam int IX_RXD     = 'h00;
    localparam int IX_TXD     = 'h10;
    localparam int IX_CTRL1   = 'h20;
    localparam int IX_CTRL2   = 'h21;
    localparam int IX_CTRL3   = 'h22;
    localparam int IX_CTRL4   = 'h23;
    localparam int IX_FIFOCTL = 'h24;
    localparam int IX_STAT1   = 'h25;
    localparam int IX_STAT2   = 'h26;
    localparam int IX_BINC    = 'h29;
    localparam int IX_BMOD    = 'h2A;
    localparam int IX_BCNT    = 'h2B;
    localparam int IX_MSEC    = 'h2C;
    localparam int IX_TEST    = 'h2D;

    // Status 1
    localparam int S1_RTS_LVL = 14;
    localparam int S1_TX_RDY  = 13;
    localparam int S1_RX_RDY  = 9;
    localparam int S1_RX_IDLE = 6;
    // Status 2
    localparam int S2_TX_EMPTY = 14;
    localparam int S2_CD_IN    = 5;
    localparam int S2_TX_CMPL  = 3;
    localparam int S2_BRK_SEEN = 2;
    localparam int S2_DATA_RDY = 0;
    // Test register
    localparam int TS_TX_EMPTY = 6;
    localparam int TS_RX_EMPTY = 5;
    // Control 1
    localparam int C1_TXRDY_EN  = 13;
    localparam int C1_RXRDY_EN  = 9;
    localparam int C1_TXEMPT_EN = 6;
    // Control 2
    localparam int C2_SOFT_N = 0;
    localparam int C2_TX_EN  = 2;
    // Control 4
    localparam int C4_CMPL_EN = 3;
    localparam int C4_DRDY_EN = 0;
    // Receive word
    localparam int RW_VALID = 15;
    localparam int RW_ERR   = 14;
    localparam int RW_FRM   = 12;
    localparam int RW_BRK   = 11;

    localparam logic [15:0] CTRL3_INIT = 16'h0700;
    localparam logic [15:0] BCNT_INIT  = 16'h0004;
    localparam logic [15:0] RXW_INIT   = 16'h4000;

    typedef enum logic [1:0] {TX_IDLE, TX_SEND, TX_WAIT} tx_state_t;
    typedef enum logic       {RX_EMPTY, RX_FULL}         rx_state_t;

endpackage

// File: rtl/uart_rb_txseq.sv
module uart_rb_txseq
    import uart_rb_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              srst,
    input  logic              start,
    input  logic [CHAR_W-1:0] din,
    input  logic              done,
    output logic              tx_strobe,
    output logic [CHAR_W-1:0] tx_data,
    output logic              idle
);

    tx_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: if (start) state_d = TX_SEND;
            TX_SEND: state_d = done ? TX_IDLE : TX_WAIT;
            TX_WAIT: if (done) state_d = TX_IDLE;
            default: state_d = TX_IDLE;
        endcase
        if (srst) state_d = TX_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  tx_data <= '0;
        else if (state_q == TX_IDLE && start && !srst) tx_data <= din;
    end

    always_comb begin
        tx_strobe = (state_q == TX_SEND);
        idle      = (state_q == TX_IDLE);
    end

    // R8: the start pulse lasts a single cycle
    p_strobe_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_strobe |=> !tx_strobe);

    // R8: a strobe only follows an accepted start request
    p_strobe_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_strobe) |-> $past(start));

endmodule

// File: rtl/uart_rb_rxbuf.sv
module uart_rb_rxbuf
    import uart_rb_pkg::*;
#(
    parameter int CHAR_W = 8,
    parameter int REG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              srst,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_data,
    input  logic              rx_brk,
    input  logic              rx_frm,
    input  logic              rx_err,
    input  logic              pop,
    output logic [REG_W-1:0]  word,
    output logic              full,
    output logic              brk_cap
);

    rx_state_t state_q, state_d;
    logic [REG_W-1:0] cap;
    logic take;

    always_comb begin
        cap = '0;
        cap[CHAR_W-1:0] = rx_data;
        cap[RW_ERR]     = rx_err;
        cap[RW_FRM]     = rx_frm;
        cap[RW_BRK]     = rx_brk;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_EMPTY: if (rx_valid) state_d = RX_FULL;
            RX_FULL:  if (pop)      state_d = RX_EMPTY;
            default:                state_d = RX_EMPTY;
        endcase
        if (srst) state_d = RX_EMPTY;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_EMPTY;
        else        state_q <= state_d;
    end

    assign take = (state_q == RX_EMPTY) && rx_valid && !srst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    word <= RXW_INIT;
        else if (srst) word <= RXW_INIT;
        else if (take) word <= cap;
    end

    always_comb begin
        full    = (state_q == RX_FULL);
        brk_cap = take && rx_brk;
    end

    // R6: an arrival while full leaves the held word alone
    p_refuse_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (full && rx_valid && !pop && !srst) |=> (full && $stable(word)));

endmodule

// File: rtl/uart_rb_irq.sv
module uart_rb_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_rdy,
    input  logic rx_rdy,
    input  logic tx_empty,
    input  logic tx_cmpl,
    input  logic data_rdy,
    input  logic en_tx_rdy,
    input  logic en_rx_rdy,
    input  logic en_tx_empty,
    input  logic en_cmpl,
    input  logic en_drdy,
    output logic irq
);

    logic any_d;

    always_comb begin
        any_d = (tx_rdy   && en_tx_rdy)   ||
                (rx_rdy   && en_rx_rdy)   ||
                (tx_empty && en_tx_empty) ||
                (tx_cmpl  && en_cmpl)     ||
                (data_rdy && en_drdy);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= any_d;
    end

    // R9: no enable set in the previous cycle means no request now
    p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!(en_tx_rdy || en_rx_rdy || en_tx_empty || en_cmpl || en_drdy)) |-> !irq);

endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
    import uart_rb_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    parameter int REG_W  = 16,
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_data,
    input  logic              rx_brk,
    input  logic              rx_frm,
    input  logic              rx_err,
    output logic              rx_ready,
    output logic              tx_strobe,
    output logic [CHAR_W-1:0] tx_data,
    input  logic              tx_done,
    output logic              irq
);

    localparam int PAD_W = DATA_W - REG_W;

    logic [REG_W-1:0] ctrl1, ctrl2, ctrl3, ctrl4, fifoctl, bmod, bcnt, msec;
    logic [REG_W-1:0] stat1, stat2, testr, rxw, rd_val, wv;
    logic brk_seen, brk_cap, rx_full, tx_idle;
    logic srst, tx_start, rx_pop;
    logic unused_hi;

    function automatic logic at(input logic [ADDR_W-1:0] a, input int ix);
        return a == ADDR_W'(ix);
    endfunction

    assign wv        = wdata[REG_W-1:0];
    assign unused_hi = ^wdata[DATA_W-1:REG_W];
    assign srst      = wr_en && at(addr, IX_CTRL2) && !wdata[C2_SOFT_N];
    assign tx_start  = wr_en && at(addr, IX_TXD) && ctrl2[C2_TX_EN];
    assign rx_pop    = rd_en && at(addr, IX_RXD);
    assign rx_ready  = !rx_full;

    uart_rb_rxbuf #(.CHAR_W(CHAR_W), .REG_W(REG_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .srst(srst),
        .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_brk(rx_brk), .rx_frm(rx_frm), .rx_err(rx_err),
        .pop(rx_pop), .word(rxw), .full(rx_full), .brk_cap(brk_cap)
    );

    uart_rb_txseq #(.CHAR_W(CHAR_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .srst(srst), .start(tx_start),
        .din(wdata[CHAR_W-1:0]), .done(tx_done),
        .tx_strobe(tx_strobe), .tx_data(tx_data), .idle(tx_idle)
    );

    // Configuration words
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl1 <= '0;  ctrl2 <= REG_W'(1); ctrl3 <= CTRL3_INIT; ctrl4 <= '0;
            fifoctl <= '0; bmod <= '0; bcnt <= BCNT_INIT; msec <= '0;
        end else if (srst) begin
            ctrl1 <= '0;
            ctrl2 <= wv | REG_W'(1);
            ctrl3 <= CTRL3_INIT;
            bmod  <= '0;
            bcnt  <= BCNT_INIT;
        end else if (wr_en) begin
            if (at(addr, IX_CTRL1))   ctrl1   <= wv;
            if (at(addr, IX_CTRL2))   ctrl2   <= wv;
            if (at(addr, IX_CTRL3))   ctrl3   <= wv;
            if (at(addr, IX_CTRL4))   ctrl4   <= wv;
            if (at(addr, IX_FIFOCTL)) fifoctl <= wv;
            if (at(addr, IX_BINC))    bcnt    <= wv;
            if (at(addr, IX_BMOD))    bmod    <= wv;
            if (at(addr, IX_MSEC))    msec    <= wv;
        end
    end

    // Break-seen: set by capture, cleared by writing one, reset by soft reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       brk_seen <= 1'b0;
        else if (srst)    brk_seen <= 1'b0;
        else if (brk_cap) brk_seen <= 1'b1;
        else if (wr_en && at(addr, IX_STAT2) && wdata[S2_BRK_SEEN]) brk_seen <= 1'b0;
    end

    always_comb begin
        stat1 = '0;
        stat1[S1_RTS_LVL] = 1'b1;
        stat1[S1_TX_RDY]  = tx_idle;
        stat1[S1_RX_RDY]  = rx_full;
        stat1[S1_RX_IDLE] = 1'b1;
        stat2 = '0;
        stat2[S2_TX_EMPTY] = 1'b1;
        stat2[S2_CD_IN]    = 1'b1;
        stat2[S2_TX_CMPL]  = tx_idle;
        stat2[S2_BRK_SEEN] = brk_seen;
        stat2[S2_DATA_RDY] = rx_full;
        testr = '0;
        testr[TS_TX_EMPTY] = 1'b1;
        testr[TS_RX_EMPTY] = !rx_full;
    end

    always_comb begin
        rd_val = '0;
        if (at(addr, IX_RXD)) begin
            rd_val = rxw;
            rd_val[RW_VALID] = rxw[RW_VALID] | rx_full;
        end
        if (at(addr, IX_CTRL1))   rd_val = ctrl1;
        if (at(addr, IX_CTRL2))   rd_val = ctrl2;
        if (at(addr, IX_CTRL3))   rd_val = ctrl3;
        if (at(addr, IX_CTRL4))   rd_val = ctrl4;
        if (at(addr, IX_FIFOCTL)) rd_val = fifoctl;
        if (at(addr, IX_STAT1))   rd_val = stat1;
        if (at(addr, IX_STAT2))   rd_val = stat2;
        if (at(addr, IX_BMOD))    rd_val = bmod;
        if (at(addr, IX_BCNT))    rd_val = bcnt;
        if (at(addr, IX_MSEC))    rd_val = msec;
        if (at(addr, IX_TEST))    rd_val = testr;
        rdata = rd_en ? {{PAD_W{1'b0}}, rd_val} : '0;
    end

    uart_rb_irq u_irq (
        .clk(clk), .rst_n(rst_n),
        .tx_rdy(stat1[S1_TX_RDY]), .rx_rdy(stat1[S1_RX_RDY]),
        .tx_empty(stat2[S2_TX_EMPTY]), .tx_cmpl(stat2[S2_TX_CMPL]),
        .data_rdy(stat2[S2_DATA_RDY]),
        .en_tx_rdy(ctrl1[C1_TXRDY_EN]), .en_rx_rdy(ctrl1[C1_RXRDY_EN]),
        .en_tx_empty(ctrl1[C1_TXEMPT_EN]),
        .en_cmpl(ctrl4[C4_CMPL_EN]), .en_drdy(ctrl4[C4_DRDY_EN]),
        .irq(irq)
    );

    // R5: reading a full buffer empties it
    p_pop_on_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && at(addr, IX_RXD) && rx_full && !srst) |=> !rx_full);

    // R3: after a soft reset the buffer is empty and the sequencer idle
    p_soft_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (!rx_full && tx_idle));

endmodule

// File: tb/tb_uart_regbank.sv
`timescale 1ns/1ps
module tb_uart_regbank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rx_valid = 1'b0, rx_brk = 1'b0, rx_frm = 1'b0, rx_err = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready, tx_strobe, tx_done = 1'b0, irq;
    logic [7:0]  tx_data;

    int n_total = 0, n_pass = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    uart_regbank dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_brk(rx_brk), .rx_frm(rx_frm), .rx_err(rx_err), .rx_ready(rx_ready),
        .tx_strobe(tx_strobe), .tx_data(tx_data), .tx_done(tx_done), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_total++;
        if (got === exp) n_pass++;
        else $display("FAIL %s: actual 0x%0h expected 0x%0h", req, got, exp);
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd_check(input string req, input logic [5:0] a, input logic [31:0] exp);
        rd_en = 1'b1; addr = a;
        #1 check(req, rdata, exp);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic send(input logic [7:0] d, input logic b, input logic f, input logic e);
        rx_valid = 1'b1; rx_data = d; rx_brk = b; rx_frm = f; rx_err = e;
        @(negedge clk);
        rx_valid = 1'b0; rx_brk = 1'b0; rx_frm = 1'b0; rx_err = 1'b0;
    endtask

    task automatic t_reset_state;
        check("R1 irq", irq, 0);
        check("R1 rx_ready", rx_ready, 1);
        check("R1 tx_strobe", tx_strobe, 0);
        rd_check("R1 stat1", 6'h25, 32'h6040);
        rd_check("R1 stat2", 6'h26, 32'h4028);
        rd_check("R1 test", 6'h2D, 32'h0060);
        rd_check("R1 ctrl1", 6'h20, 32'h0000);
        rd_check("R1 ctrl2", 6'h21, 32'h0001);
        rd_check("R1 ctrl3", 6'h22, 32'h0700);
        rd_check("R1 bmod", 6'h2A, 32'h0000);
        rd_check("R1 bcnt", 6'h2B, 32'h0004);
        rd_check("R1 rxword", 6'h00, 32'h4000);
    endtask

    task automatic t_config;
        wr(6'h22, 32'hDEAD_BEEF);
        rd_check("R2 ctrl3 low half", 6'h22, 32'h0000_BEEF);
        wr(6'h3F, 32'h0000_FFFF);
        rd_check("R2 unmapped", 6'h3F, 32'h0);
        wr(6'h29, 32'h0001_1234);
        rd_check("R2 incr to count", 6'h2B, 32'h1234);
        rd_check("R2 incr reads 0", 6'h29, 32'h0);
        wr(6'h2D, 32'hFFFF);
        rd_check("R2 test ignores write", 6'h2D, 32'h0060);
        rd_check("R2 tx index reads 0", 6'h10, 32'h0);
        wr(6'h00, 32'h1234);
        rd_check("R2 rx index write ignored", 6'h00, 32'h4000);
    endtask

    task automatic t_receive;
        send(8'h5A, 0, 0, 0);
        check("R6 ready low when full", rx_ready, 0);
        rd_check("R4 stat1 rx ready", 6'h25, 32'h6240);
        rd_check("R4 stat2 data ready", 6'h26, 32'h4029);
        rd_check("R4 test rx empty cleared", 6'h2D, 32'h0040);
        send(8'h33, 1, 0, 0);
        rd_check("R6 refused arrival", 6'h26, 32'h4029);
        rd_check("R5 read pops with valid", 6'h00, 32'h805A);
        check("R6 ready after pop", rx_ready, 1);
        rd_check("R5 empty read no valid", 6'h00, 32'h005A);
        rd_check("R5 stat1 after pop", 6'h25, 32'h6040);
        send(8'h00, 1, 1, 1);
        rd_check("R4 break seen", 6'h26, 32'h402D);
        rd_check("R4 break word", 6'h00, 32'hD800);
    endtask

    task automatic t_w1c;
        wr(6'h25, 32'hFFFF);
        rd_check("R7 stat1 unchanged", 6'h25, 32'h6040);
        wr(6'h26, 32'hFFFB);
        rd_check("R7 stat2 other ones ignored", 6'h26, 32'h402C);
        wr(6'h26, 32'h0004);
        rd_check("R7 break cleared", 6'h26, 32'h4028);
    endtask

    task automatic t_transmit;
        wr(6'h10, 32'h41);
        check("R8 no strobe when disabled", tx_strobe, 0);
        rd_check("R8 stat1 idle when disabled", 6'h25, 32'h6040);
        wr(6'h21, 32'h0005);
        rd_check("R8 enable write not reset", 6'h22, 32'hBEEF);
        wr(6'h10, 32'h1C3);
        check("R8 strobe high", tx_strobe, 1);
        check("R8 tx data", tx_data, 8'hC3);
        cyc(1);
        check("R8 strobe single", tx_strobe, 0);
        rd_check("R8 stat1 busy", 6'h25, 32'h4040);
        rd_check("R8 stat2 busy", 6'h26, 32'h4020);
        wr(6'h10, 32'h77);
        check("R8 busy write no strobe", tx_strobe, 0);
        check("R8 busy write data kept", tx_data, 8'hC3);
        tx_done = 1'b1; cyc(1); tx_done = 1'b0;
        rd_check("R8 stat1 done", 6'h25, 32'h6040);
        rd_check("R8 stat2 done", 6'h26, 32'h4028);
    endtask

    task automatic t_irq;
        check("R9 quiet", irq, 0);
        wr(6'h20, 32'h2000);
        check("R10 irq not yet", irq, 0);
        cyc(1);
        check("R9 tx ready term", irq, 1);
        wr(6'h20, 32'h0); cyc(1);
        check("R9 cleared", irq, 0);
        wr(6'h20, 32'h0040); cyc(1);
        check("R9 tx empty term", irq, 1);
        wr(6'h20, 32'h0200); cyc(1);
        check("R9 rx ready enabled, empty", irq, 0);
        send(8'h11, 0, 0, 0); cyc(1);
        check("R9 rx ready term", irq, 1);
        rd_check("R5 pop for irq", 6'h00, 32'h8011);
        check("R10 irq holds one cycle", irq, 1);
        cyc(1);
        check("R9 rx term gone", irq, 0);
        wr(6'h20, 32'h0);
        wr(6'h23, 32'h0008); cyc(1);
        check("R9 complete term", irq, 1);
        wr(6'h23, 32'h0001); cyc(1);
        check("R9 data ready enabled, empty", irq, 0);
        send(8'h22, 0, 0, 0); cyc(1);
        check("R9 data ready term", irq, 1);
        rd_check("R5 pop data", 6'h00, 32'h8022);
        cyc(1);
        check("R9 data term gone", irq, 0);
    endtask

    task automatic t_soft_reset;
        wr(6'h23, 32'h0005);
        wr(6'h24, 32'h00AB);
        wr(6'h2C, 32'h03E8);
        wr(6'h2A, 32'h0055);
        wr(6'h20, 32'h0001);
        send(8'h99, 1, 0, 0);
        wr(6'h10, 32'h12);
        cyc(1);
        wr(6'h21, 32'h0006);
        rd_check("R3 ctrl2 forced bit", 6'h21, 32'h0007);
        rd_check("R3 ctrl1", 6'h20, 32'h0);
        rd_check("R3 ctrl3", 6'h22, 32'h0700);
        rd_check("R3 bmod", 6'h2A, 32'h0);
        rd_check("R3 bcnt", 6'h2B, 32'h0004);
        rd_check("R3 ctrl4 kept", 6'h23, 32'h0005);
        rd_check("R3 fifoctl kept", 6'h24, 32'h00AB);
        rd_check("R3 msec kept", 6'h2C, 32'h03E8);
        rd_check("R3 stat1", 6'h25, 32'h6040);
        rd_check("R3 stat2", 6'h26, 32'h4028);
        rd_check("R3 test", 6'h2D, 32'h0060);
        rd_check("R3 rxword", 6'h00, 32'h4000);
        check("R3 rx_ready", rx_ready, 1);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        t_reset_state();
        t_config();
        t_receive();
        t_w1c();
        t_transmit();
        t_irq();
        t_soft_reset();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_pass, n_total);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            finished = 1;
            n_total++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_pass, n_total);
            $finish;
        end
    end

endmodule